// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This unit repairs the binary result of a byte addition or subtraction of two packed BCD operands so that it becomes a valid two-digit packed BCD value. It does not perform the original arithmetic. It receives the raw accumulator byte together with three flags from that earlier operation: the carry (or borrow) out of the top bit, the half-carry (or borrow) at the digit boundary between bits 3 and 4, and a direction flag. The direction flag records whether the earlier operation was an addition or a subtraction, and the two cases need different correction rules.

For each request the unit adds or subtracts a correction of 0x00, 0x06, 0x60 or 0x66. It then presents the corrected byte with new carry, zero, sign and overflow flags. All outputs are registered. An optional input register stage, selected by a parameter, gives a latency of one or two cycles. Between requests the outputs keep their last values. An input byte that is not valid BCD gives a defined result, but that result has no arithmetic meaning.

Top module: `dadj_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the following edge leaves `out_valid` low, `out_acc` at 0x00, and all four output flags low.
- R2: When `in_dir_sub` is 0 (addition), the unit adds 0x06 whenever the low nibble of `in_acc` is above 9 or `in_half` is 1.
- R3: When `in_dir_sub` is 0 (addition), the unit adds 0x60 whenever `in_acc` is above 0x99 or `in_carry` is 1. `out_carry` is 1 exactly in that case.
- R4: When `in_dir_sub` is 1 (subtraction), the unit subtracts 0x06 if `in_half` is 1 and subtracts 0x60 if `in_carry` is 1. `out_carry` equals `in_carry`.
- R5: `out_zero` is 1 exactly when the corrected byte is 0x00. `out_sign` equals bit 7 of the corrected byte.
- R6: `out_ovf` is 1 when the correction step, read as a signed 8-bit addition of `in_acc` and the signed correction (+corr for addition, -corr for subtraction), leaves the range -128..127.
- R7: `out_valid` is high exactly `1+IN_REG` cycles after `in_valid` was sampled high. The results of that request appear in the same cycle.
- R8: While `out_valid` is low, the outputs keep their previous values. Input values presented with `in_valid` low have no effect on them.
- R9: For BCD operands a and b, when the raw byte, half-carry and carry come from a+b (or from a-b), the corrected byte is the packed BCD of (a+b) mod 100 (or of (a-b) mod 100). `out_carry` is 1 when the sum reaches 100 (or when a<b).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_acc | input | DATA_W | Raw binary result of the earlier operation |
| in_carry | input | 1 | Carry or borrow from the top bit of the earlier operation |
| in_half | input | 1 | Carry or borrow at the bit 3/4 boundary |
| in_dir_sub | input | 1 | 0 = earlier operation was an addition, 1 = a subtraction |
| out_valid | output | 1 | Result strobe |
| out_acc | output | DATA_W | Corrected packed BCD byte |
| out_carry | output | 1 | New carry flag |
| out_zero | output | 1 | Corrected byte is zero |
| out_sign | output | 1 | Bit 7 of the corrected byte |
| out_ovf | output | 1 | Signed overflow of the correction step |

## Verification
The bench targets cases where only one of the two digit corrections is needed. A unit that tied the two nibble decisions together would add 0x66 to 0x09+0x01, or 0x06 to 0x50+0x50. It also drives sums that wrap past 0x99 into a zero byte with the carry set (0x99+0x01, 0x50+0x50). A unit that ignored the threshold test, or took zero from the raw byte, would report 0x9A or a clear zero flag. It runs subtractions that borrow into 0x99 and checks that the carry passes through unchanged. A unit that recomputed carry with the addition rule would lose the borrow. It also feeds 0x79+0x01, whose correction crosses into the negative range and must raise overflow, and it puts idle cycles carrying garbage inputs between requests to expose any output that moves without a strobe.

// File: rtl/dadj_pkg.sv
package dadj_pkg;

  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;
  localparam logic [DIGIT_W-1:0] DIGIT_FIX = 4'd6;

  typedef enum logic {
    DIR_ADD = 1'b0,
    DIR_SUB = 1'b1
  } adj_dir_e;

  typedef struct packed {
    logic carry;
    logic zero;
    logic sign;
    logic ovf;
  } adj_flags_t;

endpackage

// File: rtl/dadj_detect.sv
module dadj_detect
  import dadj_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc,
  input  logic              carry_in,
  input  logic              half_in,
  input  adj_dir_e          dir,
  output logic              lo_fix,
  output logic              hi_fix,
  output logic              carry_next
);

  localparam int DIGITS = DATA_W / DIGIT_W;
  localparam logic [DATA_W-1:0] BCD_MAX = {DIGITS{DIGIT_MAX}};

  logic lo_big;
  logic whole_big;

  // Threshold tests use the raw byte, before any correction is applied
  assign lo_big    = acc[DIGIT_W-1:0] > DIGIT_MAX;
  assign whole_big = acc > BCD_MAX;

  always_comb begin
    case (dir)
      DIR_SUB: begin
        // Borrows alone decide; no digit can exceed 9 after a BCD subtract
        lo_fix     = half_in;
        hi_fix     = carry_in;
        carry_next = carry_in;
      end
      default: begin
        lo_fix     = lo_big | half_in;
        hi_fix     = whole_big | carry_in;
        carry_next = whole_big | carry_in;
      end
    endcase
  end

endmodule

// File: rtl/dadj_apply.sv
module dadj_apply
  import dadj_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc,
  input  logic              lo_fix,
  input  logic              hi_fix,
  input  logic              carry_next,
  input  adj_dir_e          dir,
  output logic [DATA_W-1:0] res,
  output adj_flags_t        flags
);

  localparam int DIGITS = DATA_W / DIGIT_W;
  localparam int MSB    = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] corr;
  logic [DATA_W-1:0] addend;

  // Per-digit correction constant: lowest digit follows lo_fix,
  // top digit follows hi_fix, any digit between stays zero
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    if (g == 0) begin : g_lo
      assign corr[g*DIGIT_W +: DIGIT_W] = lo_fix ? DIGIT_FIX : '0;
    end else if (g == DIGITS - 1) begin : g_hi
      assign corr[g*DIGIT_W +: DIGIT_W] = hi_fix ? DIGIT_FIX : '0;
    end else begin : g_mid
      assign corr[g*DIGIT_W +: DIGIT_W] = '0;
    end
  end

  // One adder serves both directions via two's-complement negation
  assign addend = (dir == DIR_SUB) ? (~corr + ONE) : corr;
  assign res    = acc + addend;

  always_comb begin
    flags.carry = carry_next;
    flags.zero  = (res == '0);
    flags.sign  = res[MSB];
    flags.ovf   = (acc[MSB] == addend[MSB]) && (res[MSB] != acc[MSB]);
  end

endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
  import dadj_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit IN_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_acc,
  input  logic              in_carry,
  input  logic              in_half,
  input  logic              in_dir_sub,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_acc,
  output logic              out_carry,
  output logic              out_zero,
  output logic              out_sign,
  output logic              out_ovf
);

  logic              st_valid;
  logic [DATA_W-1:0] st_acc;
  logic              st_carry;
  logic              st_half;
  adj_dir_e          st_dir;

  if (IN_REG) begin : g_in_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        st_valid <= 1'b0;
        st_acc   <= '0;
        st_carry <= 1'b0;
        st_half  <= 1'b0;
        st_dir   <= DIR_ADD;
      end else begin
        st_valid <= in_valid;
        if (in_valid) begin
          st_acc   <= in_acc;
          st_carry <= in_carry;
          st_half  <= in_half;
          st_dir   <= adj_dir_e'(in_dir_sub);
        end
      end
    end
  end else begin : g_in_pass
    assign st_valid = in_valid;
    assign st_acc   = in_acc;
    assign st_carry = in_carry;
    assign st_half  = in_half;
    assign st_dir   = adj_dir_e'(in_dir_sub);
  end

  logic              lo_fix;
  logic              hi_fix;
  logic              carry_next;
  logic [DATA_W-1:0] fixed;
  adj_flags_t        fixed_flags;

  dadj_detect #(.DATA_W(DATA_W)) detect_i (
    .acc        (st_acc),
    .carry_in   (st_carry),
    .half_in    (st_half),
    .dir        (st_dir),
    .lo_fix     (lo_fix),
    .hi_fix     (hi_fix),
    .carry_next (carry_next)
  );

  dadj_apply #(.DATA_W(DATA_W)) apply_i (
    .acc        (st_acc),
    .lo_fix     (lo_fix),
    .hi_fix     (hi_fix),
    .carry_next (carry_next),
    .dir        (st_dir),
    .res        (fixed),
    .flags      (fixed_flags)
  );

  adj_flags_t        flags_q;
  logic [DATA_W-1:0] acc_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      acc_q   <= '0;
      flags_q <= '0;
    end else begin
      valid_q <= st_valid;
      if (st_valid) begin
        acc_q   <= fixed;
        flags_q <= fixed_flags;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_acc   = acc_q;
  assign out_carry = flags_q.carry;
  assign out_zero  = flags_q.zero;
  assign out_sign  = flags_q.sign;
  assign out_ovf   = flags_q.ovf;

endmodule

// File: rtl/dadj_unit_chk.sv
module dadj_unit_chk #(
  parameter int DATA_W = 8,
  parameter bit IN_REG = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_carry,
  input logic              in_dir_sub,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_acc,
  input logic              out_carry,
  input logic              out_zero,
  input logic              out_sign,
  input logic              out_ovf
);

  localparam int LAT = 1 + int'(IN_REG);
  localparam int MSB = DATA_W - 1;

  logic [1:0] warm;
  logic       rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R1: a second reset edge sees cleared outputs
  always @(posedge clk) begin
    if (rst_d === 1'b1 && rst === 1'b1) begin
      assert_reset_clear_R1: assert (!out_valid && out_acc == '0 && !out_carry
                                     && !out_zero && !out_sign && !out_ovf)
        else $error("reset state not cleared");
    end
  end

  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && !out_valid) |-> ($stable(out_acc) && $stable(out_carry)
                                     && $stable(out_zero) && $stable(out_ovf)));

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_zero == (out_acc == '0)));

  assert_sign_flag_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sign == out_acc[MSB]));

  assert_sub_carry_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'(LAT) && out_valid && $past(in_dir_sub, LAT))
      |-> (out_carry == $past(in_carry, LAT)));

  assert_add_carry_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'(LAT) && out_valid && !$past(in_dir_sub, LAT) && $past(in_carry, LAT))
      |-> out_carry);

  assert_ovf_direction_R6: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'(LAT) && out_valid && out_ovf)
      |-> (out_sign == !$past(in_dir_sub, LAT)));

endmodule

bind dadj_unit dadj_unit_chk #(.DATA_W(DATA_W), .IN_REG(IN_REG)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_carry   (in_carry),
  .in_dir_sub (in_dir_sub),
  .out_valid  (out_valid),
  .out_acc    (out_acc),
  .out_carry  (out_carry),
  .out_zero   (out_zero),
  .out_sign   (out_sign),
  .out_ovf    (out_ovf)
);

// File: tb/dadj_unit_tb_top.sv
`timescale 1ns/1ps
module dadj_unit_tb_top;

  localparam int DATA_W = 8;
  localparam bit IN_REG = 1'b1;
  localparam int LAT    = 1 + int'(IN_REG);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DATA_W-1:0] in_acc = '0;
  logic in_carry = 1'b0, in_half = 1'b0, in_dir_sub = 1'b0;
  logic out_valid, out_carry, out_zero, out_sign, out_ovf;
  logic [DATA_W-1:0] out_acc;

  always #2.5 clk = ~clk;

  dadj_unit #(.DATA_W(DATA_W), .IN_REG(IN_REG)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_acc(in_acc),
    .in_carry(in_carry), .in_half(in_half), .in_dir_sub(in_dir_sub),
    .out_valid(out_valid), .out_acc(out_acc), .out_carry(out_carry),
    .out_zero(out_zero), .out_sign(out_sign), .out_ovf(out_ovf)
  );

  typedef struct {
    int    due;
    int    res;
    bit    c, z, s, v;
    string rtag;
    string ctag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;
  int   last_res = 0;
  bit   last_c = 0, last_z = 0, last_s = 0, last_v = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int to_bcd(int d);
    return ((d / 10) << 4) | (d % 10);
  endfunction

  function automatic int from_bcd(int b);
    return (b >> 4) * 10 + (b & 15);
  endfunction

  function automatic int sx(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // Model the earlier BCD operation, then push the expected corrected result
  task automatic send(int a, int b, bit sub);
    int bin, full, res, k, sv, da, db, dec;
    bit c, h, cout;
    exp_t e;
    da = from_bcd(a);
    db = from_bcd(b);
    if (!sub) begin
      full = a + b;
      h    = ((a & 15) + (b & 15)) > 15;
      c    = full > 255;
      dec  = da + db;
      cout = dec >= 100;
      res  = to_bcd(dec % 100);
    end else begin
      full = a - b;
      h    = (a & 15) < (b & 15);
      c    = a < b;
      dec  = da - db;
      cout = da < db;
      res  = to_bcd((dec + 100) % 100);
    end
    bin = full & 255;
    k   = (res - bin) & 255;
    sv  = sx(bin) + sx(k);
    @(negedge clk);
    in_valid   = 1'b1;
    in_acc     = bin[DATA_W-1:0];
    in_carry   = c;
    in_half    = h;
    in_dir_sub = sub;
    e.due = cyc + LAT;
    e.res = res;
    e.c   = cout;
    e.z   = (res == 0);
    e.s   = res[7];
    e.v   = (sv > 127) || (sv < -128);
    if (sub) e.rtag = "R4";
    else if (c || bin > 'h99) e.rtag = "R3";
    else if (h || (bin & 15) > 9) e.rtag = "R2";
    else e.rtag = "R9";
    e.ctag = sub ? "R4" : "R3";
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid   = 1'b0;
      in_acc     = DATA_W'($urandom_range(0, 255));
      in_carry   = 1'($urandom_range(0, 1));
      in_half    = 1'($urandom_range(0, 1));
      in_dir_sub = 1'($urandom_range(0, 1));
    end
  endtask

  // Reference comparison on every cycle
  always @(negedge clk) begin
    if (mon_en) begin
      bit ev;
      exp_t e;
      ev = (q.size() > 0) && (q[0].due == cyc);
      chk("R7", "out_valid", int'(out_valid), int'(ev));
      if (ev) begin
        e = q.pop_front();
        chk(e.rtag, "result", int'(out_acc), e.res);
        chk("R9", "bcd digits", int'(out_acc[3:0] <= 9 && out_acc[7:4] <= 9), 1);
        chk(e.ctag, "carry", int'(out_carry), int'(e.c));
        chk("R5", "zero", int'(out_zero), int'(e.z));
        chk("R5", "sign", int'(out_sign), int'(e.s));
        chk("R6", "overflow", int'(out_ovf), int'(e.v));
        last_res = e.res; last_c = e.c; last_z = e.z; last_s = e.s; last_v = e.v;
      end else begin
        chk("R8", "held result", int'(out_acc), last_res);
        chk("R8", "held flags", int'({out_carry, out_zero, out_sign, out_ovf}),
            int'({last_c, last_z, last_s, last_v}));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset valid", int'(out_valid), 0);
    chk("R1", "reset result", int'(out_acc), 0);
    chk("R1", "reset flags", int'({out_carry, out_zero, out_sign, out_ovf}), 0);
    rst = 1'b0;
    mon_en = 1'b1;

    send('h09, 'h01, 0);  // R2: low nibble above 9 -> 0x10
    send('h08, 'h08, 0);  // R2: half-carry only -> 0x16
    idle(2);
    send('h50, 'h50, 0);  // R3: high digit only, zero with carry
    send('h99, 'h01, 0);  // R3: both corrections, wraps to 0x00
    send('h99, 'h99, 0);  // R3: carry in set -> 0x98
    send('h45, 'h45, 0);  // R5: sign set on 0x90
    send('h79, 'h01, 0);  // R6: correction crosses +127
    idle(3);
    send('h00, 'h01, 1);  // R4: double borrow -> 0x99
    send('h10, 'h01, 1);  // R4: low borrow -> 0x09
    send('h42, 'h42, 1);  // R5: zero after subtract
    send('h20, 'h30, 1);  // R4: high borrow only -> 0x90
    idle(2);

    for (int i = 0; i < 400; i++) begin
      send(to_bcd($urandom_range(0, 99)), to_bcd($urandom_range(0, 99)),
           1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end

    idle(LAT + 3);
    chk("R7", "pending results", q.size(), 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule